// File: doc/BRIEF.md
# SerDes Control Register Access Master

This block turns single register requests into the bus traffic needed to reach an internal SerDes register. A requester presents a 16-bit SerDes register address, a direction and, for writes, a 16-bit data word, then holds its request until the acknowledge. The SerDes exposes only three command registers: a control register at SerDes address 0x80A0, an address register at 0x80A1 and a data register at 0x80A2. These are reached through a paged window on a small synchronous register bus.

Every register touch is a pair of bus transfers. First a page word is written to bus offset 0x800. Then the register itself is accessed at a word-aligned offset. The block polls the control register until it is no longer busy. It then loads the target address into the address register, loads the data register on writes, and pulses the start bit. A read polls again and then fetches the data register. A poll that stays busy for too long ends the command with a timeout flag.

Top module: `sdcr_access_master`

## Requirements
- R1: Every SerDes register access on the bus is directly preceded by a write to bus offset 0x800 of the page word `dev_id_i << 7 | reg_addr[15:9]`. No other transfer and no idle cycle falls between the page write and its access. The command registers therefore use page word `dev_id_i << 7 | 0x40`.
- R2: The bus offset of SerDes register address A is `A[8:0] << 2`. This gives offset 0x280 for control, 0x284 for address and 0x288 for data.
- R3: A read runs these steps in order: poll control, write the requested address to the address register, write 0x0001 to control, poll control again, read the data register. `cmd_rdata_o` then carries the value read from the data register.
- R4: A write runs these steps in order: poll control, write the address register, write the data register, write 0x0003 to control. It then acknowledges with no further bus transfer.
- R5: A control read with bit 0 set means busy. The block re-reads control after the bus has been idle for at least POLL_GAP and at most POLL_GAP+2 cycles.
- R6: When POLL_LIMIT consecutive control reads of one poll phase all show busy, the command ends. It acknowledges with `cmd_timeout_o` high and makes no further bus transfer.
- R7: `cmd_ack_o` is a single-cycle pulse in the cycle after the command's final bus acknowledge is sampled. `cmd_timeout_o` is low on a command that completes normally.
- R8: Out of reset, `cmd_ack_o` and `bus_req_o` are low. While the block is idle and `cmd_req_i` is low, no bus transfer starts.
- R9: Once `bus_req_o` is raised, it stays high with `bus_addr_o`, `bus_we_o` and `bus_wdata_o` unchanged until `bus_ack_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_id_i | input | DEV_W | Device number placed in the page word |
| cmd_req_i | input | 1 | Command request, held until acknowledge |
| cmd_we_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 16 | SerDes register address |
| cmd_wdata_i | input | DW | Write data |
| cmd_ack_o | output | 1 | Command done pulse |
| cmd_rdata_o | output | DW | Read result, valid with acknowledge |
| cmd_timeout_o | output | 1 | Busy poll limit reached, valid with acknowledge |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | Bus transfer is a write |
| bus_addr_o | output | BUS_AW | Bus byte offset |
| bus_wdata_o | output | DW | Bus write data |
| bus_ack_i | input | 1 | Bus transfer complete |
| bus_rdata_i | input | DW | Bus read data, valid with acknowledge |

## Verification
The command acknowledge is due exactly one cycle after the final bus acknowledge is sampled. The bench stamps both events with a cycle counter, so the check is an exact difference of one, followed by a check that the pulse is gone in the next cycle. The poll interval depends on the register stages between a busy reply and the next request. The bench therefore counts idle bus cycles after each busy reply and accepts the window from POLL_GAP to POLL_GAP+2. All bus values are sampled on the falling edge, when they are stable. The command sequence, page words and offsets are decoded by a register model on the bus side and compared against the expected list of steps.

// File: rtl/sdcr_pkg.sv
package sdcr_pkg;
  localparam int REG_AW = 16;
  localparam logic [15:0] CTL_REG = 16'h80A0;
  localparam logic [15:0] ADR_REG = 16'h80A1;
  localparam logic [15:0] DAT_REG = 16'h80A2;
  localparam logic [11:0] WIN_OFF = 12'h800;
  localparam logic [15:0] GO_RD   = 16'h0001;
  localparam logic [15:0] GO_WR   = 16'h0003;

  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_GAP, S_ADDR, S_DATA, S_START, S_READ, S_DONE
  } seq_e;

  typedef enum logic [1:0] {X_IDLE, X_SEL, X_ACC} xst_e;
endpackage

// File: rtl/sdcr_win_xfer.sv
module sdcr_win_xfer import sdcr_pkg::*; #(
  parameter int DW     = 16,
  parameter int DEV_W  = 5,
  parameter int BUS_AW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DEV_W-1:0]  dev_i,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DW-1:0]     bus_rdata_i
);
  localparam int WORD_W = DEV_W + 7;

  xst_e st_q;
  logic [WORD_W-1:0] page_word;

  assign page_word = {dev_i, reg_addr_i[15:9]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= X_IDLE;
    else begin
      case (st_q)
        X_IDLE:  if (go_i) st_q <= X_SEL;
        X_SEL:   if (bus_ack_i) st_q <= X_ACC;
        X_ACC:   if (bus_ack_i) st_q <= X_IDLE;
        default: st_q <= X_IDLE;
      endcase
    end
  end

  // page select and register access go out back to back
  assign bus_req_o   = (st_q != X_IDLE);
  assign bus_we_o    = (st_q == X_SEL) | we_i;
  assign bus_addr_o  = (st_q == X_SEL) ? BUS_AW'(WIN_OFF)
                                       : BUS_AW'({reg_addr_i[8:0], 2'b00});
  assign bus_wdata_o = (st_q == X_SEL) ? DW'(page_word) : wdata_i;
  assign done_o      = (st_q == X_ACC) && bus_ack_i;
  assign rdata_o     = bus_rdata_i;

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                && $stable(bus_we_o) && $stable(bus_wdata_o));

  p_pair_atomic_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> $past(bus_addr_o) != BUS_AW'(WIN_OFF));
endmodule

// File: rtl/sdcr_poll_timer.sv
module sdcr_poll_timer #(
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_GAP   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic busy_hit_i,
  output logic gap_done_o,
  output logic last_try_o
);
  localparam int TW = $clog2(POLL_LIMIT + 1);
  localparam int GW = $clog2(POLL_GAP + 1);

  logic [TW-1:0] tries_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tries_q <= '0;
      gap_q   <= '0;
    end else begin
      if (clr_i)           tries_q <= '0;
      else if (busy_hit_i) tries_q <= tries_q + TW'(1);
      if (busy_hit_i)      gap_q <= GW'(POLL_GAP - 1);
      else if (gap_q != 0) gap_q <= gap_q - GW'(1);
    end
  end

  assign gap_done_o = (gap_q == 0);
  assign last_try_o = (tries_q == TW'(POLL_LIMIT - 1));

  p_try_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= TW'(POLL_LIMIT));
endmodule

// File: rtl/sdcr_access_master.sv
module sdcr_access_master import sdcr_pkg::*; #(
  parameter int DW         = 16,
  parameter int DEV_W      = 5,
  parameter int BUS_AW     = 12,
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_GAP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEV_W-1:0]  dev_id_i,
  input  logic              cmd_req_i,
  input  logic              cmd_we_i,
  input  logic [REG_AW-1:0] cmd_addr_i,
  input  logic [DW-1:0]     cmd_wdata_i,
  output logic              cmd_ack_o,
  output logic [DW-1:0]     cmd_rdata_o,
  output logic              cmd_timeout_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DW-1:0]     bus_rdata_i
);
  seq_e st_q;
  logic we_q, post_q, to_q;
  logic [REG_AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  logic x_go, x_we, x_done;
  logic [REG_AW-1:0] x_addr;
  logic [DW-1:0] x_wdata, x_rdata;
  logic busy_hit, gap_done, last_try, tmr_clr;

  always_comb begin
    x_go    = 1'b1;
    x_we    = 1'b0;
    x_addr  = CTL_REG;
    x_wdata = '0;
    case (st_q)
      S_POLL:  ;
      S_ADDR:  begin x_we = 1'b1; x_addr = ADR_REG; x_wdata = DW'(addr_q); end
      S_DATA:  begin x_we = 1'b1; x_addr = DAT_REG; x_wdata = wdata_q; end
      S_START: begin x_we = 1'b1; x_wdata = we_q ? DW'(GO_WR) : DW'(GO_RD); end
      S_READ:  x_addr = DAT_REG;
      default: x_go = 1'b0;
    endcase
  end

  assign busy_hit = (st_q == S_POLL) && x_done && x_rdata[0];
  assign tmr_clr  = (st_q == S_IDLE) || (st_q == S_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      we_q    <= 1'b0;
      post_q  <= 1'b0;
      to_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cmd_req_i) begin
          we_q    <= cmd_we_i;
          addr_q  <= cmd_addr_i;
          wdata_q <= cmd_wdata_i;
          post_q  <= 1'b0;
          to_q    <= 1'b0;
          st_q    <= S_POLL;
        end
        S_POLL: if (x_done) begin
          if (x_rdata[0]) begin
            if (last_try) begin to_q <= 1'b1; st_q <= S_DONE; end
            else st_q <= S_GAP;
          end else st_q <= post_q ? S_READ : S_ADDR;
        end
        S_GAP:   if (gap_done) st_q <= S_POLL;
        S_ADDR:  if (x_done) st_q <= we_q ? S_DATA : S_START;
        S_DATA:  if (x_done) st_q <= S_START;
        S_START: if (x_done) begin
          // writes do not wait for completion
          if (we_q) st_q <= S_DONE;
          else begin post_q <= 1'b1; st_q <= S_POLL; end
        end
        S_READ: if (x_done) begin rdata_q <= x_rdata; st_q <= S_DONE; end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ack_o     = (st_q == S_DONE);
  assign cmd_timeout_o = (st_q == S_DONE) && to_q;
  assign cmd_rdata_o   = rdata_q;

  sdcr_win_xfer #(.DW(DW), .DEV_W(DEV_W), .BUS_AW(BUS_AW)) u_xfer (
    .clk_i, .rst_ni,
    .go_i(x_go), .we_i(x_we), .reg_addr_i(x_addr), .wdata_i(x_wdata),
    .dev_i(dev_id_i), .done_o(x_done), .rdata_o(x_rdata),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_ack_i, .bus_rdata_i
  );

  sdcr_poll_timer #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .busy_hit_i(busy_hit),
    .gap_done_o(gap_done), .last_try_o(last_try)
  );

  p_ack_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |=> !cmd_ack_o);

  p_ack_has_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |-> $past(cmd_req_i));

  p_gap_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_GAP |-> !bus_req_o);

  p_to_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_timeout_o |-> $past(bus_ack_i) && $past(bus_rdata_i[0]));
endmodule

// File: tb/tb_sdcr_access_master.sv
module tb_sdcr_access_master;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 6;
  localparam int GAP = 3;

  logic clk = 0, rst_n = 0;
  logic [4:0] dev_id = 5'h02;
  logic cmd_req = 0, cmd_we = 0;
  logic [15:0] cmd_addr = 0, cmd_wdata = 0;
  logic cmd_ack, cmd_to;
  logic [15:0] cmd_rdata;
  logic bus_req, bus_we, bus_ack = 0;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcr_access_master #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_id_i(dev_id),
    .cmd_req_i(cmd_req), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .cmd_ack_o(cmd_ack), .cmd_rdata_o(cmd_rdata),
    .cmd_timeout_o(cmd_to), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack),
    .bus_rdata_i(bus_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // bus-side register model
  logic [15:0] mem [0:255];
  logic [11:0] win = 0, last_win = 0;
  logic [15:0] areg = 0, dreg = 0;
  logic fresh = 0, stuck = 0, holding = 0, gap_pend = 0;
  int busy_left = 0, busy_after = 0, lat = 0, wcnt = 0;
  int pair_err = 0, stab_err = 0, win_n = 0, last_ack_cyc = 0;
  int idle_cnt = 0, gmin = 0, gmax = 0, gap_n = 0;
  int lg_n = 0;
  int lg_kind [0:63];
  logic [15:0] lg_val [0:63];
  logic [11:0] h_addr;
  logic [15:0] h_wdata;
  logic h_we;

  task automatic log_it(input int k, input logic [15:0] v);
    if (lg_n < 64) begin lg_kind[lg_n] = k; lg_val[lg_n] = v; end
    lg_n++;
  endtask

  task automatic do_xfer();
    logic [15:0] full;
    logic bsy;
    if (bus_addr == 12'h800) begin
      if (!bus_we || fresh) pair_err++;
      win = bus_wdata[11:0]; last_win = win; fresh = 1; win_n++;
    end else begin
      if (!fresh) pair_err++;
      fresh = 0;
      if (bus_addr[1:0] != 0 || bus_addr[11]) pair_err++;
      if (win[11:7] != dev_id) pair_err++;
      full = {win[6:0], bus_addr[10:2]};
      case (full)
        16'h80A0: if (bus_we) begin
          log_it(4, bus_wdata);
          if (bus_wdata[0]) begin
            busy_left = busy_after;
            if (bus_wdata[1]) mem[areg[7:0]] = dreg; else dreg = mem[areg[7:0]];
          end
        end else begin
          bsy = stuck || (busy_left > 0);
          if (busy_left > 0) busy_left--;
          bus_rdata = {15'h0, bsy};
          log_it(1, {15'h0, bsy});
          if (bsy) begin gap_pend = 1; idle_cnt = 0; end
        end
        16'h80A1: if (bus_we) begin areg = bus_wdata; log_it(2, bus_wdata); end
                  else log_it(7, 0);
        16'h80A2: if (bus_we) begin dreg = bus_wdata; log_it(3, bus_wdata); end
                  else begin bus_rdata = dreg; log_it(5, dreg); end
        default: log_it(7, full);
      endcase
    end
    bus_ack = 1;
    last_ack_cyc = cyc;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    forever begin
      @(negedge clk);
      cyc++;
      if (gap_pend) begin
        if (!bus_req) idle_cnt++;
        else begin
          if (gap_n == 0 || idle_cnt < gmin) gmin = idle_cnt;
          if (gap_n == 0 || idle_cnt > gmax) gmax = idle_cnt;
          gap_n++; gap_pend = 0;
        end
      end
      if (bus_ack) bus_ack = 0;
      else if (bus_req) begin
        if (!holding) begin
          holding = 1; h_addr = bus_addr; h_we = bus_we; h_wdata = bus_wdata;
        end else if (h_addr != bus_addr || h_we != bus_we || h_wdata != bus_wdata)
          stab_err++;
        if (wcnt < lat) wcnt++;
        else begin wcnt = 0; holding = 0; do_xfer(); end
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic clear_log();
    lg_n = 0; win_n = 0; pair_err = 0; stab_err = 0; gap_n = 0;
  endtask

  logic [15:0] got_rd;
  logic got_to;
  int got_lat;

  task automatic run_cmd(input logic we, input logic [15:0] a, input logic [15:0] d);
    int t;
    @(negedge clk);
    cmd_we = we; cmd_addr = a; cmd_wdata = d; cmd_req = 1;
    t = 0;
    do begin @(negedge clk); t++; end while (!cmd_ack && t < 5000);
    if (!cmd_ack) begin
      n_chk++; n_fail++;
      $display("FAIL R7 no acknowledge act=0 exp=1");
    end
    got_rd = cmd_rdata; got_to = cmd_to; got_lat = cyc - last_ack_cyc;
    cmd_req = 0;
    @(negedge clk);
    chk("R7 ack lasts one cycle", {31'h0, cmd_ack}, 32'h0);
  endtask

  task automatic exp_step(input string r, input int i, input int k, input logic [15:0] v);
    chk(r, lg_kind[i], k);
    chk(r, {16'h0, lg_val[i]}, {16'h0, v});
  endtask

  task automatic t_reset();
    chk("R8 reset ack", {31'h0, cmd_ack}, 0);
    chk("R8 reset bus_req", {31'h0, bus_req}, 0);
    chk("R8 reset timeout", {31'h0, cmd_to}, 0);
  endtask

  task automatic t_write_basic();
    clear_log(); busy_after = 0; lat = 0;
    run_cmd(1, 16'h1234, 16'hBEEF);
    chk("R4 write step count", lg_n, 4);
    exp_step("R4 poll", 0, 1, 16'h0);
    exp_step("R4 addr reg", 1, 2, 16'h1234);
    exp_step("R4 data reg", 2, 3, 16'hBEEF);
    exp_step("R4 start write", 3, 4, 16'h0003);
    chk("R2 data landed at offset", {16'h0, mem[8'h34]}, {16'h0, 16'hBEEF});
    chk("R1 one page write per access", win_n, lg_n);
    chk("R1 pairing", pair_err, 0);
    chk("R7 ack one cycle after last bus ack", got_lat, 1);
    chk("R7 no timeout", {31'h0, got_to}, 0);
  endtask

  task automatic t_read_busy();
    clear_log(); busy_after = 2; lat = 0;
    mem[8'h5A] = 16'hC0DE;
    run_cmd(0, 16'h205A, 16'h0);
    chk("R3 read step count", lg_n, 7);
    exp_step("R3 poll", 0, 1, 16'h0);
    exp_step("R3 addr reg", 1, 2, 16'h205A);
    exp_step("R3 start read", 2, 4, 16'h0001);
    exp_step("R5 busy poll", 3, 1, 16'h1);
    exp_step("R5 busy poll", 4, 1, 16'h1);
    exp_step("R3 final poll", 5, 1, 16'h0);
    exp_step("R3 data read", 6, 5, 16'hC0DE);
    chk("R3 rdata", {16'h0, got_rd}, {16'h0, 16'hC0DE});
    chk("R5 gap count", gap_n, 2);
    chk("R5 gap min", {31'h0, gmin >= GAP}, 1);
    chk("R5 gap max", {31'h0, gmax <= GAP + 2}, 1);
    chk("R1 pairing", pair_err, 0);
    chk("R7 ack timing", got_lat, 1);
  endtask

  task automatic t_prebusy_latency();
    clear_log(); busy_after = 0; lat = 2; busy_left = 3;
    run_cmd(1, 16'hFF01, 16'h5555);
    chk("R5 step count", lg_n, 7);
    exp_step("R5 first poll busy", 0, 1, 16'h1);
    exp_step("R5 last poll clear", 3, 1, 16'h0);
    exp_step("R4 addr after polls", 4, 2, 16'hFF01);
    exp_step("R4 start write", 6, 4, 16'h0003);
    chk("R9 stable while waiting", stab_err, 0);
    chk("R5 gap min", {31'h0, gmin >= GAP}, 1);
    chk("R5 gap max", {31'h0, gmax <= GAP + 2}, 1);
    chk("R1 pairing under latency", pair_err, 0);
    chk("R7 ack timing", got_lat, 1);
    lat = 0;
  endtask

  task automatic t_dev_page();
    dev_id = 5'h13;
    clear_log(); busy_after = 0;
    run_cmd(0, 16'h0034, 16'h0);
    chk("R1 page word", {20'h0, last_win}, 32'h9C0);
    chk("R1 pairing", pair_err, 0);
    chk("R2 read back", {16'h0, got_rd}, {16'h0, 16'hBEEF});
    dev_id = 5'h02;
  endtask

  task automatic t_timeout();
    clear_log(); stuck = 1;
    run_cmd(1, 16'h0001, 16'h0001);
    chk("R6 poll count", lg_n, LIMIT);
    for (int i = 0; i < LIMIT; i++) exp_step("R6 only busy polls", i, 1, 16'h1);
    chk("R6 timeout flag", {31'h0, got_to}, 1);
    stuck = 0; busy_left = 0;
    clear_log();
    run_cmd(0, 16'h0034, 16'h0);
    chk("R7 timeout clear after success", {31'h0, got_to}, 0);
    chk("R3 read after timeout", {16'h0, got_rd}, {16'h0, 16'hBEEF});
  endtask

  task automatic t_idle_quiet();
    int hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_req) hits++;
    end
    chk("R8 idle bus quiet", hits, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_idle_quiet();
    t_write_basic();
    t_read_busy();
    t_prebusy_latency();
    t_dev_page();
    t_timeout();
    t_idle_quiet();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule